// File: doc/BRIEF.md
# Converter clock prescaler with on-demand gating

This block sits in front of a data converter. It makes a one-cycle clock-enable strobe at a rate set by dividing the peripheral clock by a power of two. It also decides, cycle by cycle, whether the converter should be running. That decision uses five inputs: an enable bit, an on-demand mode bit, a run-in-standby policy bit, the system standby state, and a request line driven by other peripherals.

In on-demand mode the converter runs only while some peripheral is asking for a conversion. In standby the converter is stopped unless the run-in-standby policy allows it. When that policy allows it, the on-demand rule applies unchanged. The converter core and the sleep controller are outside this block. The block only reports the running state and paces conversions with the strobe.

Top module: `conv_clk_gate`

## Requirements
- R1: A 3-bit divide code n (0..7) on `div_sel_i` gives one `conv_stb_o` pulse, one cycle wide, every 2^(n+1) running cycles (2 up to 256). Two strobes never fall in adjacent cycles.
- R2: With `enable_i`=1, `on_demand_i`=0 and `standby_i`=0, `running_o` is 1.
- R3: With `on_demand_i`=1, `running_o` is 1 only when `req_i` was 1. With no request, the converter is halted.
- R4: With `standby_i`=1 and `run_stby_i`=0, `running_o` is 0 whatever the other inputs are.
- R5: With `standby_i`=1 and `run_stby_i`=1, the on-demand rule applies. The converter is always on when `on_demand_i`=0, and on only while `req_i`=1 when `on_demand_i`=1.
- R6: `running_o` is registered. It reflects the inputs sampled at the previous rising edge, and it is never 1 when `enable_i` was 0 at that edge.
- R7: While halted, the divider is held at zero and no strobe is made. After a halted-to-running transition, the first strobe comes in the 2^(n+1)-th running cycle.
- R8: A change of `div_sel_i` while running takes effect only at the next divider wrap. The period in progress finishes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Converter enable |
| on_demand_i | input | 1 | 1: run only while a peripheral requests |
| run_stby_i | input | 1 | 1: keep running in standby |
| standby_i | input | 1 | System is in standby |
| req_i | input | 1 | Conversion request from other peripherals |
| div_sel_i | input | 3 | Divide code n, ratio 2^(n+1) |
| conv_stb_o | output | 1 | Conversion clock-enable strobe |
| running_o | output | 1 | Converter running status |

## Verification
Two events can land in the same cycle: a divider wrap, and a change of the divide code or of the run decision. The random phase changes the inputs after hold times of arbitrary length, so code changes and request drops often fall on a wrap cycle or just before one. The directed phase also switches the code in the middle of a period. The bench keeps its own count of cycles within each divided period. It decides from the requirements whether the old or the new ratio, or a fresh restart, governs each strobe, and it compares every cycle's strobe and running outputs against that count.

// File: rtl/conv_clk_pkg.sv
package conv_clk_pkg;
  typedef enum logic [1:0] {
    RUN_OFF    = 2'd0,
    RUN_ALWAYS = 2'd1,
    RUN_ON_REQ = 2'd2
  } run_mode_e;
endpackage

// File: rtl/conv_run_ctrl.sv
module conv_run_ctrl
  import conv_clk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic on_demand_i,
  input  logic run_stby_i,
  input  logic standby_i,
  input  logic req_i,
  output logic run_o
);
  run_mode_e mode;
  logic      run_d, run_q;

  always_comb begin
    if (!enable_i || (standby_i && !run_stby_i)) mode = RUN_OFF;
    else if (on_demand_i)                         mode = RUN_ON_REQ;
    else                                          mode = RUN_ALWAYS;
  end

  always_comb begin
    unique case (mode)
      RUN_ALWAYS: run_d = 1'b1;
      RUN_ON_REQ: run_d = req_i;
      default:    run_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_d;
  end

  assign run_o = run_q;

  AST_RUN_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> $past(enable_i)); // R6
  AST_OD_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(on_demand_i)) |-> $past(req_i)); // R3
  AST_STBY_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> !$past(standby_i && !run_stby_i)); // R4
  AST_ALWAYS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !on_demand_i && (!standby_i || run_stby_i)) |=> run_q); // R2
endmodule

// File: rtl/conv_pow2_div.sv
module conv_pow2_div #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned CNT_W = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             stb_o
);
  logic [SEL_W-1:0] code_q;
  logic [CNT_W-1:0] cnt_q, lim;
  logic [CNT_W:0]   span;
  logic             wrap;

  // ratio 2^(code+1); terminal count one less
  assign span = (CNT_W+1)'(2) << code_q;
  assign lim  = CNT_W'(span - 1'b1);
  assign wrap = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      code_q <= sel_i;
    end else if (wrap) begin
      cnt_q  <= '0;
      code_q <= sel_i;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign stb_o = wrap;

  AST_START_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (cnt_q == '0)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim); // R1
  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap) |=> $stable(code_q)); // R8
endmodule

// File: rtl/conv_clk_gate.sv
module conv_clk_gate #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             on_demand_i,
  input  logic             run_stby_i,
  input  logic             standby_i,
  input  logic             req_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             conv_stb_o,
  output logic             running_o
);
  logic run;

  conv_run_ctrl i_run_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .on_demand_i (on_demand_i),
    .run_stby_i  (run_stby_i),
    .standby_i   (standby_i),
    .req_i       (req_i),
    .run_o       (run)
  );

  conv_pow2_div #(.SEL_W(SEL_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sel_i  (div_sel_i),
    .stb_o  (conv_stb_o)
  );

  assign running_o = run;

  AST_STB_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_stb_o |=> !conv_stb_o); // R1
  AST_NO_STB_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |=> !conv_stb_o); // R7
endmodule

// File: tb/test_conv_clk_gate.sv
`timescale 1ns/1ps
module test_conv_clk_gate;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en = 0, od = 0, rs = 0, sb = 0, req = 0;
  logic [2:0] sel = '0;
  logic       stb, running;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit    m_run = 0, m_first = 1, m_chg = 0;
  int    m_cnt = 0, m_code = 0;
  string run_tag = "R6";

  always #2 clk = ~clk;

  conv_clk_gate i_conv_clk_gate (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(en), .on_demand_i(od),
    .run_stby_i(rs), .standby_i(sb), .req_i(req), .div_sel_i(sel),
    .conv_stb_o(stb), .running_o(running)
  );

  function automatic int lim_of(int c);
    return (2 << c) - 1;
  endfunction

  task automatic check(bit act, bit exp, string tag, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // one cycle: check outputs, drive new inputs, advance the expected model
  task automatic cyc(bit e, bit o, bit r, bit s, bit q, int c);
    bit want;
    string stag;
    @(negedge clk);
    stag = m_first ? "R7" : (m_chg ? "R8" : "R1");
    check(running, m_run, run_tag, "running_o");
    check(stb, m_run && (m_cnt == lim_of(m_code)), stag, "conv_stb_o");
    en = e; od = o; rs = r; sb = s; req = q; sel = 3'(c);
    want = e && (!s || r) && (!o || q);
    if (!e)           run_tag = "R6";
    else if (s && !r) run_tag = "R4";
    else if (s)       run_tag = "R5";
    else if (o)       run_tag = "R3";
    else              run_tag = "R2";
    if (!m_run) begin
      m_cnt = 0; m_code = c; m_first = 1; m_chg = 0;
    end else if (m_cnt == lim_of(m_code)) begin
      m_cnt = 0; m_first = 0; m_chg = (c != m_code); m_code = c;
    end else begin
      m_cnt++;
    end
    m_run = want;
  endtask

  task automatic hold(int n, bit e, bit o, bit r, bit s, bit q, int c);
    for (int i = 0; i < n; i++) cyc(e, o, r, s, q, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    check(running, 1'b0, "R6", "running_o in reset");
    check(stb, 1'b0, "R7", "conv_stb_o in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    hold(3, 0, 0, 0, 0, 0, 0);           // R6 disabled
    hold(12, 1, 0, 0, 0, 0, 0);          // R2 R1 div 2
    hold(30, 1, 0, 0, 0, 0, 2);          // R8 switch to div 8
    hold(5, 1, 0, 0, 0, 0, 5);           // R8 change mid period
    hold(150, 1, 0, 0, 0, 0, 5);
    hold(40, 1, 0, 0, 0, 0, 1);
    hold(20, 1, 1, 0, 0, 1, 1);          // R3 requested
    hold(6, 1, 1, 0, 0, 0, 1);           // R3 no request
    hold(20, 1, 1, 0, 0, 1, 2);          // R7 restart
    hold(10, 1, 0, 0, 1, 1, 0);          // R4 standby halts
    hold(10, 1, 1, 0, 1, 1, 0);
    hold(20, 1, 0, 1, 1, 0, 1);          // R5 always in standby
    hold(8, 1, 1, 1, 1, 0, 1);           // R5 on demand, idle
    hold(20, 1, 1, 1, 1, 1, 1);          // R5 on demand, requested
    hold(8, 0, 0, 1, 0, 1, 1);           // R6 enable low
    hold(600, 1, 0, 0, 0, 0, 7);         // R1 div 256
    for (int k = 0; k < 400; k++) begin
      int n, c;
      bit e, o, r, s, q;
      n = 1 + int'($urandom % 64);
      e = ($urandom % 10) != 0;
      o = ($urandom % 2) != 0;
      r = ($urandom % 3) != 0;
      s = ($urandom % 4) == 0;
      q = ($urandom % 10) < 7;
      c = (($urandom % 3) == 0) ? int'($urandom % 8) : int'($urandom % 3);
      hold(n, e, o, r, s, q, c);
    end
    hold(2, 0, 0, 0, 0, 0, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule